// File: doc/BRIEF.md
# Hashed Page Table Group Walker

After a translation miss this block searches a hashed page table held in memory. It takes the 32-bit effective address, picks a segment register with the address's top nibble, and derives two page-table-group addresses from an XOR hash of the segment ID and the page number. The table-base register supplies the table origin and the mask that folds the high hash bits into the group address.

The walker then reads the entries of the primary group one at a time over a 32-bit read port with a request/valid handshake. Each entry's upper word is compared exactly against a compare word built from the segment ID and the page index. On the first hit it fetches that entry's lower word and reports success. If all eight primary entries miss, it repeats the scan over the secondary group with the hash-select bit set in the compare word. After sixteen failed compares it reports a miss.

Both group addresses stay on outputs for software whether or not the primary search hits. The compare word last used is kept on one of two outputs, one for instruction fetches and one for data accesses.

Top module: `hptw_walker`

## Requirements
- R1: After reset, busy, done, found and mem_rd_req are 0, and cmp_fetch and cmp_data are 0.
- R2: On the cycle after an accepted start, grp_pri equals {tbase[31:25], tbase[24:16] | (H[18:10] & tbase[8:0]), H[9:0], 6'b0}. H is the 19-bit primary hash: the low 19 bits of the segment ID XOR ea[27:12]. The segment ID is the 24-bit register selected by ea[31:28].
- R3: grp_sec is formed the same way from H XOR 0x7FFFF. It is valid on the cycle after start, including when the primary search hits.
- R4: The compare word has bit 31 = 1, bits [30:7] = segment ID, bit 6 = hash-select (0 for the primary search) and bits [5:0] = ea[27:22].
- R5: Entry i of a group is read as an upper word at group+8·i and, after a hit, a lower word at group+8·i+4. Entries are taken in index order from 0. Only one request is open at a time, and mem_rd_req and mem_rd_addr hold steady until mem_rd_valid.
- R6: The scan stops at the first upper word equal to the compare word. The walker reads that entry's lower word, pulses done for one cycle with found = 1, and puts the lower word on pte_lo.
- R7: The secondary group is scanned only after all eight primary entries miss, and with bit 6 of the compare word set. A primary entry that carries bit 6 set does not match, and neither does a secondary entry that carries bit 6 clear.
- R8: When neither group matches, done pulses with found = 0 after exactly 16 upper-word reads and no lower-word read.
- R9: When is_fetch was 1 at start, the compare word used goes to cmp_fetch; otherwise it goes to cmp_data. The other output keeps its value. After the secondary search starts, the output shows the word with bit 6 set.
- R10: A start pulse while busy is 1 is ignored. The search in progress and its group addresses are unchanged.
- R11: Segment register k is written with seg_we, seg_widx = k and seg_wdata. The written value is the segment ID used for every later address whose bits [31:28] equal k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment register write enable |
| seg_widx | input | 4 | Segment register index to write |
| seg_wdata | input | 24 | Segment ID to write |
| tbase | input | 32 | Table base: origin in [31:16], mask in [8:0] |
| start | input | 1 | Begin a walk (taken only when idle) |
| ea | input | 32 | Effective address that missed |
| is_fetch | input | 1 | 1 for an instruction fetch miss, 0 for data |
| mem_rd_req | output | 1 | Read request, held until mem_rd_valid |
| mem_rd_addr | output | 32 | Byte address of the word being read |
| mem_rd_valid | input | 1 | Read data valid for one cycle |
| mem_rd_data | input | 32 | Read data, big-endian word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| found | output | 1 | Last walk found a matching entry |
| pte_lo | output | 32 | Lower word of the matching entry |
| grp_pri | output | 32 | Primary group address |
| grp_sec | output | 32 | Secondary group address |
| cmp_fetch | output | 32 | Compare word of the last fetch walk |
| cmp_data | output | 32 | Compare word of the last data walk |

## Verification
The group addresses and the first compare word are registered at the edge that takes start. The bench therefore checks grp_pri, grp_sec and the selected compare output at the first falling edge after that edge. The memory model answers after a configurable latency of zero to three cycles. done rises one cycle after the edge that samples the final mem_rd_valid, so found, pte_lo, the final compare word and the read counts are checked at the falling edge where done is high. The read count follows from the planted hit position alone: i+2 reads for a primary hit at entry i, 10+j for a secondary hit at entry j, and 16 for a miss. This count does not depend on latency. The bench compares it, and the logged first addresses of each group, against values it computes arithmetically.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_HI   = 2'd1,
      WK_LO   = 2'd2
   } wk_state_t;

   function automatic logic [31:0] swap_bytes32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/hptw_segfile.sv
module hptw_segfile #(
   parameter int SEG_CNT = 16,
   parameter int SID_W   = 24,
   parameter int SEL_W   = $clog2(SEG_CNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_idx,
   input  logic [SID_W-1:0] wr_data,
   input  logic [SEL_W-1:0] rd_idx,
   output logic [SID_W-1:0] rd_data
);

   logic [SID_W-1:0] regs [SEG_CNT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < SEG_CNT; k++) regs[k] <= '0;
      end else if (wr_en) begin
         regs[wr_idx] <= wr_data;
      end
   end

   assign rd_data = regs[rd_idx];

endmodule

// File: rtl/hptw_hash.sv
module hptw_hash #(
   parameter int SID_W     = 24,
   parameter int PIDX_W    = 6,
   parameter int MASK_W    = 9,
   parameter int GRP_SH    = 6,
   parameter int LOW_H     = 16 - GRP_SH,
   parameter int HASH_W    = LOW_H + MASK_W
) (
   input  logic [SID_W-1:0] sid,
   input  logic [31:0]      ea,
   input  logic [31:0]      tbase,
   output logic [31:0]      grp_a,
   output logic [31:0]      grp_b,
   output logic [31:0]      cmp_word
);

   localparam int ORG_LO = 16 + MASK_W;

   logic [HASH_W-1:0] h_pri;
   logic [31:0]       grp [2];

   assign h_pri = sid[HASH_W-1:0] ^ HASH_W'(ea[27:12]);

   for (genvar g = 0; g < 2; g++) begin : g_grp
      logic [HASH_W-1:0] h;
      assign h = (g == 0) ? h_pri : (h_pri ^ {HASH_W{1'b1}});
      assign grp[g] = {tbase[31:ORG_LO],
                       tbase[ORG_LO-1:16] | (h[HASH_W-1:LOW_H] & tbase[MASK_W-1:0]),
                       h[LOW_H-1:0],
                       {GRP_SH{1'b0}}};
   end

   assign grp_a    = grp[0];
   assign grp_b    = grp[1];
   assign cmp_word = {1'b1, sid, 1'b0, ea[27:28-PIDX_W]};

endmodule

// File: rtl/hptw_seq.sv
module hptw_seq
   import hptw_pkg::*;
#(
   parameter int ENTRY_CNT = 8,
   parameter int PIDX_W    = 6,
   parameter int IDX_W     = $clog2(ENTRY_CNT)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        is_fetch,
   input  logic [31:0] grp_a_in,
   input  logic [31:0] grp_b_in,
   input  logic [31:0] cmp_in,
   output logic        mem_rd_req,
   output logic [31:0] mem_rd_addr,
   input  logic        mem_rd_valid,
   input  logic [31:0] rd_word,
   output logic        busy,
   output logic        done,
   output logic        found,
   output logic [31:0] pte_lo,
   output logic [31:0] grp_pri,
   output logic [31:0] grp_sec,
   output logic [31:0] cmp_fetch,
   output logic [31:0] cmp_data
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_CNT - 1);
   localparam logic [31:0]      HSEL     = 32'(1) << PIDX_W;
   localparam int               OFF_W    = IDX_W + 3;

   wk_state_t        state;
   logic [IDX_W-1:0] idx;
   logic             in_sec;
   logic             kind_fetch;
   logic [31:0]      cmp_cur;
   logic [OFF_W-1:0] offset;
   logic [31:0]      base;

   assign offset      = {idx, state == WK_LO, 2'b00};
   assign base        = in_sec ? grp_sec : grp_pri;
   assign mem_rd_addr = base | 32'(offset);
   assign mem_rd_req  = (state == WK_HI) || (state == WK_LO);
   assign busy        = (state != WK_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= WK_IDLE;
         idx        <= '0;
         in_sec     <= 1'b0;
         kind_fetch <= 1'b0;
         cmp_cur    <= '0;
         done       <= 1'b0;
         found      <= 1'b0;
         pte_lo     <= '0;
         grp_pri    <= '0;
         grp_sec    <= '0;
         cmp_fetch  <= '0;
         cmp_data   <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            WK_IDLE: begin
               if (start) begin
                  grp_pri    <= grp_a_in;
                  grp_sec    <= grp_b_in;
                  cmp_cur    <= cmp_in;
                  kind_fetch <= is_fetch;
                  idx        <= '0;
                  in_sec     <= 1'b0;
                  found      <= 1'b0;
                  pte_lo     <= '0;
                  if (is_fetch) cmp_fetch <= cmp_in;
                  else          cmp_data  <= cmp_in;
                  state      <= WK_HI;
               end
            end
            WK_HI: begin
               if (mem_rd_valid) begin
                  if (rd_word == cmp_cur) begin
                     state <= WK_LO;
                  end else if (idx == LAST_IDX) begin
                     if (!in_sec) begin
                        in_sec  <= 1'b1;
                        idx     <= '0;
                        cmp_cur <= cmp_cur | HSEL;
                        if (kind_fetch) cmp_fetch <= cmp_cur | HSEL;
                        else            cmp_data  <= cmp_cur | HSEL;
                     end else begin
                        done  <= 1'b1;
                        state <= WK_IDLE;
                     end
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
            end
            WK_LO: begin
               if (mem_rd_valid) begin
                  pte_lo <= rd_word;
                  found  <= 1'b1;
                  done   <= 1'b1;
                  state  <= WK_IDLE;
               end
            end
            default: state <= WK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hptw_walker.sv
module hptw_walker #(
   parameter int SEG_CNT   = 16,
   parameter int SID_W     = 24,
   parameter int PIDX_W    = 6,
   parameter int MASK_W    = 9,
   parameter int ENTRY_CNT = 8,
   parameter bit DATA_LE   = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       seg_we,
   input  logic [$clog2(SEG_CNT)-1:0] seg_widx,
   input  logic [SID_W-1:0]           seg_wdata,
   input  logic [31:0]                tbase,
   input  logic                       start,
   input  logic [31:0]                ea,
   input  logic                       is_fetch,
   output logic                       mem_rd_req,
   output logic [31:0]                mem_rd_addr,
   input  logic                       mem_rd_valid,
   input  logic [31:0]                mem_rd_data,
   output logic                       busy,
   output logic                       done,
   output logic                       found,
   output logic [31:0]                pte_lo,
   output logic [31:0]                grp_pri,
   output logic [31:0]                grp_sec,
   output logic [31:0]                cmp_fetch,
   output logic [31:0]                cmp_data
);

   localparam int SEL_W  = $clog2(SEG_CNT);
   localparam int GRP_SH = $clog2(ENTRY_CNT * 8);
   localparam int LOW_H  = 16 - GRP_SH;
   localparam int HASH_W = LOW_H + MASK_W;

   if (SEG_CNT != 16) begin : g_bad_seg
      $error("segment file must be indexed by four address bits");
   end
   if (2 + SID_W + PIDX_W != 32) begin : g_bad_cmp
      $error("compare word fields must fill 32 bits");
   end
   if (HASH_W < 16 || HASH_W > SID_W) begin : g_bad_hash
      $error("hash width must cover the page number and fit the segment ID");
   end
   if (MASK_W >= 16 || GRP_SH >= 16) begin : g_bad_mask
      $error("mask and group offset must fit below bit 16");
   end

   logic [SID_W-1:0] sid;
   logic [31:0]      grp_a, grp_b, cmp_word, rd_word;

   hptw_segfile #(.SEG_CNT(SEG_CNT), .SID_W(SID_W), .SEL_W(SEL_W)) i_segfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_we),
      .wr_idx  (seg_widx),
      .wr_data (seg_wdata),
      .rd_idx  (ea[31:32-SEL_W]),
      .rd_data (sid)
   );

   hptw_hash #(
      .SID_W(SID_W), .PIDX_W(PIDX_W), .MASK_W(MASK_W),
      .GRP_SH(GRP_SH), .LOW_H(LOW_H), .HASH_W(HASH_W)
   ) i_hash (
      .sid      (sid),
      .ea       (ea),
      .tbase    (tbase),
      .grp_a    (grp_a),
      .grp_b    (grp_b),
      .cmp_word (cmp_word)
   );

   if (DATA_LE) begin : g_swap
      assign rd_word = hptw_pkg::swap_bytes32(mem_rd_data);
   end else begin : g_pass
      assign rd_word = mem_rd_data;
   end

   hptw_seq #(.ENTRY_CNT(ENTRY_CNT), .PIDX_W(PIDX_W)) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .is_fetch     (is_fetch),
      .grp_a_in     (grp_a),
      .grp_b_in     (grp_b),
      .cmp_in       (cmp_word),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid),
      .rd_word      (rd_word),
      .busy         (busy),
      .done         (done),
      .found        (found),
      .pte_lo       (pte_lo),
      .grp_pri      (grp_pri),
      .grp_sec      (grp_sec),
      .cmp_fetch    (cmp_fetch),
      .cmp_data     (cmp_data)
   );

endmodule

// File: rtl/hptw_chk.sv
module hptw_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        done,
   input logic        found,
   input logic        mem_rd_req,
   input logic        mem_rd_valid,
   input logic [31:0] mem_rd_addr,
   input logic [31:0] grp_pri,
   input logic [31:0] grp_sec
);

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

   // R5
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

   // R7
   in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> ((mem_rd_addr[31:6] == grp_pri[31:6]) ||
                      (mem_rd_addr[31:6] == grp_sec[31:6])));

   // R6
   found_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(found) |-> done);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(grp_pri) && $stable(grp_sec)));

endmodule

bind hptw_walker hptw_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .done         (done),
   .found        (found),
   .mem_rd_req   (mem_rd_req),
   .mem_rd_valid (mem_rd_valid),
   .mem_rd_addr  (mem_rd_addr),
   .grp_pri      (grp_pri),
   .grp_sec      (grp_sec)
);

// File: tb/test_hptw_walker.sv
module test_hptw_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_we = 1'b0;
   logic [3:0]  seg_widx = '0;
   logic [23:0] seg_wdata = '0;
   logic [31:0] tbase = '0;
   logic        start = 1'b0;
   logic [31:0] ea = '0;
   logic        is_fetch = 1'b0;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        busy, done, found;
   logic [31:0] pte_lo, grp_pri, grp_sec, cmp_fetch, cmp_data;

   always #5 clk = ~clk;

   hptw_walker i_hptw_walker (
      .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_widx(seg_widx),
      .seg_wdata(seg_wdata), .tbase(tbase), .start(start), .ea(ea),
      .is_fetch(is_fetch), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .busy(busy),
      .done(done), .found(found), .pte_lo(pte_lo), .grp_pri(grp_pri),
      .grp_sec(grp_sec), .cmp_fetch(cmp_fetch), .cmp_data(cmp_data)
   );

   int n_chk = 0;
   int n_bad = 0;

   // memory model
   logic [31:0] mem_img [logic [31:0]];
   int          lat_cfg = 0;
   int          wait_cnt = 0;
   int          up_cnt = 0;
   int          lo_cnt = 0;
   logic [31:0] up_log [0:2047];

   always @(posedge clk) begin
      mem_rd_valid <= 1'b0;
      if (!rst_n) begin
         wait_cnt <= 0;
      end else if (!mem_rd_valid && mem_rd_req) begin
         if (wait_cnt >= lat_cfg) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem_img.exists(mem_rd_addr) ? mem_img[mem_rd_addr]
                                                        : {1'b0, mem_rd_addr[30:0]};
            wait_cnt     <= 0;
            if (mem_rd_addr[2]) lo_cnt <= lo_cnt + 1;
            else begin
               up_log[up_cnt % 2048] <= mem_rd_addr;
               up_cnt <= up_cnt + 1;
            end
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   logic [23:0] seg_model [16];
   logic [31:0] last_cf = '0;
   logic [31:0] last_cd = '0;

   function automatic logic [23:0] seg_val(input int k);
      return 24'((k * 32'h13579B) ^ 32'hA5A5A5);
   endfunction

   function automatic logic [31:0] grp_of(input logic [31:0] h, input logic [31:0] tb);
      return (tb & 32'hFE00_0000) | ((h & 32'h3FF) << 6) | (tb & 32'h01FF_0000) |
             ((((h >> 10) & (tb & 32'h1FF))) << 16);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic seg_write(input int k, input logic [23:0] v);
      @(negedge clk);
      seg_we = 1'b1; seg_widx = 4'(k); seg_wdata = v;
      @(negedge clk);
      seg_we = 1'b0;
      seg_model[k] = v;
   endtask

   // mode 0: primary hit at idx, 1: secondary hit at idx, 2: miss
   task automatic run_case(input logic [31:0] a, input bit f, input logic [31:0] tb,
                           input int mode, input int idx, input int lat, input bit poke);
      logic [23:0] sid;
      logic [31:0] h1, h2, gp, gs, cp, cs, lo_exp, exp_cmp;
      int          up0, lo0, tmo;
      sid = seg_model[a[31:28]];
      h1  = (32'(sid) & 32'h7FFFF) ^ ((a >> 12) & 32'hFFFF);
      h2  = h1 ^ 32'h7FFFF;
      gp  = grp_of(h1, tb);
      gs  = grp_of(h2, tb);
      cp  = 32'h8000_0000 | (32'(sid) << 7) | ((a >> 22) & 32'h3F);
      cs  = cp | 32'h40;
      lo_exp = 32'hC0DE_0000 | 32'(mode << 8) | 32'(idx);
      mem_img.delete();
      if (mode == 0) begin
         mem_img[gp + 32'(8*idx)]     = cp;
         mem_img[gp + 32'(8*idx) + 4] = lo_exp;
         if (idx < 7) begin
            mem_img[gp + 56]     = cp;
            mem_img[gp + 60]     = 32'hBAD0_0007;
         end
      end else begin
         for (int e = 0; e < 8; e++) mem_img[gp + 32'(8*e)] = cs;
         for (int e = 0; e < 8; e++) mem_img[gs + 32'(8*e)] = cp;
         if (mode == 1) begin
            mem_img[gs + 32'(8*idx)]     = cs;
            mem_img[gs + 32'(8*idx) + 4] = lo_exp;
         end
      end
      lat_cfg = lat;
      tbase   = tb;
      @(negedge clk);
      up0 = up_cnt; lo0 = lo_cnt;
      start = 1'b1; ea = a; is_fetch = f;
      @(negedge clk);
      start = 1'b0;
      // R2 R3 R4 R9
      chk(grp_pri == gp, "R2 primary group", grp_pri, gp);
      chk(grp_sec == gs, "R3 secondary group", grp_sec, gs);
      if (f) begin
         chk(cmp_fetch == cp, "R4 fetch compare word", cmp_fetch, cp);
         chk(cmp_data == last_cd, "R9 data compare untouched", cmp_data, last_cd);
      end else begin
         chk(cmp_data == cp, "R4 data compare word", cmp_data, cp);
         chk(cmp_fetch == last_cf, "R9 fetch compare untouched", cmp_fetch, last_cf);
      end
      if (poke) begin
         // R10: start while busy
         start = 1'b1; ea = a ^ 32'h5A5A_F000; is_fetch = ~f;
         @(negedge clk);
         start = 1'b0;
         chk(grp_pri == gp, "R10 group held while busy", grp_pri, gp);
      end
      tmo = 0;
      while (!done && tmo < 3000) begin
         @(negedge clk);
         tmo++;
      end
      chk(done == 1'b1, "R6 done reached", 32'(done), 32'd1);
      exp_cmp = (mode == 0) ? cp : cs;
      if (mode == 2) begin
         chk(found == 1'b0, "R8 miss reported", 32'(found), 32'd0);
         chk(up_cnt - up0 == 16, "R8 sixteen upper reads", 32'(up_cnt - up0), 32'd16);
         chk(lo_cnt - lo0 == 0, "R8 no lower read", 32'(lo_cnt - lo0), 32'd0);
      end else begin
         chk(found == 1'b1, "R6 found", 32'(found), 32'd1);
         chk(pte_lo == lo_exp, "R6 lower word", pte_lo, lo_exp);
         chk(lo_cnt - lo0 == 1, "R5 one lower read", 32'(lo_cnt - lo0), 32'd1);
         chk(up_cnt - up0 == (mode == 0 ? idx + 1 : 9 + idx), "R6 stop at first match",
             32'(up_cnt - up0), 32'(mode == 0 ? idx + 1 : 9 + idx));
      end
      chk(up_log[up0 % 2048] == gp, "R5 first read at primary entry 0",
          up_log[up0 % 2048], gp);
      if (mode != 0)
         chk(up_log[(up0 + 8) % 2048] == gs, "R7 secondary starts at entry 0",
             up_log[(up0 + 8) % 2048], gs);
      if (f) begin
         chk(cmp_fetch == exp_cmp, "R7 final fetch compare", cmp_fetch, exp_cmp);
         last_cf = cmp_fetch;
      end else begin
         chk(cmp_data == exp_cmp, "R7 final data compare", cmp_data, exp_cmp);
         last_cd = cmp_data;
      end
      @(negedge clk);
      chk(done == 1'b0, "R6 done is one cycle", 32'(done), 32'd0);
   endtask

   logic [31:0] tbases [4];

   initial begin
      tbases[0] = 32'h0000_0000;
      tbases[1] = 32'h1234_01FF;
      tbases[2] = 32'hA5C0_0055;
      tbases[3] = 32'hFE00_0100;
      for (int k = 0; k < 16; k++) seg_model[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
      chk(done == 1'b0, "R1 done after reset", 32'(done), 0);
      chk(found == 1'b0, "R1 found after reset", 32'(found), 0);
      chk(mem_rd_req == 1'b0, "R1 request after reset", 32'(mem_rd_req), 0);
      chk(cmp_fetch == 0 && cmp_data == 0, "R1 compare outputs after reset",
          cmp_fetch | cmp_data, 0);
      // R11: program every segment register, then walk through each
      for (int k = 0; k < 16; k++) seg_write(k, seg_val(k));
      for (int c = 0; c < 48; c++) begin
         logic [31:0] a;
         a = {4'(c % 16), 28'((c * 32'h0123457) ^ 32'h0ABCDEF)};
         run_case(a, c[0], tbases[c % 4], c / 16, (c * 3) % 8, c % 4, c == 5);
      end
      // R11: rewrite one register and walk again
      seg_write(9, 24'h3C3C3C);
      run_case(32'h9876_5000, 1'b0, tbases[1], 0, 2, 1, 1'b0);
      run_case(32'h9FFF_F000, 1'b1, tbases[2], 1, 7, 0, 1'b0);
      run_case(32'h9000_0000, 1'b0, tbases[3], 2, 0, 2, 1'b0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule